// File: doc/BRIEF.md
# Dead-Time Scaler Bank

This block holds four counting scalers that let the acquisition system measure how much of the time it is unable to accept events. Two of the scalers follow the trigger: one counts every trigger, the other counts only the triggers that arrive while the system is not busy. The other two scalers follow a free-running 10 kHz pulser in the same way: one counts every pulse, the other counts only the pulses seen while busy is low. The dead-time fraction is then one minus the ratio of the vetoed pulser count to the free pulser count.

The pulser pair is the preferred reference because a pulser cannot double-trigger, while the trigger pair also shows real trigger losses. Every input is brought into the clock domain and reduced to its rising edge, so a long pulse is counted once. Counters stop at their maximum value instead of wrapping. A one-cycle software clear strobe empties all counters. A channel address selects which counter appears on the read port, and addresses with no counter read as zero.

Top module: `dtscal_bank`

## Requirements
- R1: The raw trigger counter, read at address 9, increments by one for each rising edge of `trig_in`.
- R2: The live trigger counter, read at address 10, increments by one for each rising edge of `trig_in` that arrives while `busy_in` is low; with `busy_in` high (1 = busy) trigger edges leave it unchanged.
- R3: The free pulser counter, read at address 11, increments by one for each rising edge of `pulse_in`.
- R4: The vetoed pulser counter, read at address 12, increments by one for each rising edge of `pulse_in` that arrives while `busy_in` is low; pulser edges while busy is high leave it unchanged.
- R5: An input held high for several clock cycles increments its counters only once.
- R6: Each live counter is never greater than its raw counter.
- R7: A one-cycle high on `clr_in` sets every counter to zero on the next clock edge, taking precedence over any increment in that cycle.
- R8: A counter that holds all ones stays at all ones on further edges; it does not wrap.
- R9: Any read address other than 9, 10, 11 and 12 returns zero on `rd_data`.
- R10: After a synchronous reset (`rst` high) every counter reads zero.
- R11: `rd_data` shows the counter selected by `rd_addr` in the same cycle, with no register between address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_in | input | 1 | Software clear strobe, one cycle, active high |
| trig_in | input | 1 | Raw trigger input, asynchronous |
| pulse_in | input | 1 | Free-running pulser input, asynchronous |
| busy_in | input | 1 | Busy/veto level, 1 = busy, asynchronous |
| rd_addr | input | ADDR_W (5) | Channel read address |
| rd_data | output | CNT_W (32) | Selected counter value, zero for unused addresses |

## Verification
The bench builds the block with 4-bit counters while keeping the default 5-bit address and channel map, so saturation at 15 is reached after a few dozen pulses instead of four billion. With that width every one of the 32 read addresses is swept after each phase, and the four counters are compared with a saturating model kept in the bench. It walks the busy level through both states under short and long pulses on both inputs, and clears the bank between phases.

// File: rtl/dtscal_pkg.sv
package dtscal_pkg;

    // Counted sources: trigger and pulser, each with a free and a vetoed count.
    localparam int NUM_SRC = 2;
    localparam int NUM_CH  = 2 * NUM_SRC;

    // Counter slot order inside the bank (index into the counter vector).
    typedef enum logic [1:0] {
        SLOT_TRIG_RAW   = 2'd0,
        SLOT_TRIG_LIVE  = 2'd1,
        SLOT_PULSE_RAW  = 2'd2,
        SLOT_PULSE_LIVE = 2'd3
    } slot_e;

    // One cycle worth of count requests for a single source.
    typedef struct packed {
        logic live;
        logic raw;
    } tick_t;

    // Split an edge into its free and busy-vetoed count requests.
    function automatic tick_t gate_by_busy(input logic edge_s, input logic busy_s);
        tick_t t;
        t.raw  = edge_s;
        t.live = edge_s & ~busy_s;
        return t;
    endfunction

    // Pack the per-source requests into the slot order of slot_e.
    function automatic logic [NUM_CH-1:0] pack_ticks(input tick_t trig, input tick_t pulse);
        logic [NUM_CH-1:0] v;
        v[SLOT_TRIG_RAW]   = trig.raw;
        v[SLOT_TRIG_LIVE]  = trig.live;
        v[SLOT_PULSE_RAW]  = pulse.raw;
        v[SLOT_PULSE_LIVE] = pulse.live;
        return v;
    endfunction

endpackage

// File: rtl/dtscal_sync.sv
module dtscal_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/dtscal_edge.sv
module dtscal_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level;
        end
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/dtscal_counter.sv
module dtscal_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != TOP)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign q = cnt_q;
endmodule

// File: rtl/dtscal_readmux.sv
module dtscal_readmux #(
    parameter int                         NUM_CH = 4,
    parameter int                         CNT_W  = 32,
    parameter int                         ADDR_W = 5,
    parameter logic [NUM_CH*ADDR_W-1:0]   CH_MAP = '0
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]              data
);
    always_comb begin
        data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == CH_MAP[i*ADDR_W +: ADDR_W]) begin
                data = cnt[i];
            end
        end
    end
endmodule

// File: rtl/dtscal_bank.sv
module dtscal_bank
    import dtscal_pkg::*;
#(
    parameter int CNT_W         = 32,
    parameter int ADDR_W        = 5,
    parameter int SYNC_STAGES   = 2,
    parameter int TRIG_RAW_CH   = 9,
    parameter int TRIG_LIVE_CH  = 10,
    parameter int PULSE_RAW_CH  = 11,
    parameter int PULSE_LIVE_CH = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_in,
    input  logic              trig_in,
    input  logic              pulse_in,
    input  logic              busy_in,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data
);
    // Address map in slot order (slot 0 in the low bits).
    localparam logic [NUM_CH*ADDR_W-1:0] CH_MAP = {
        ADDR_W'(PULSE_LIVE_CH),
        ADDR_W'(PULSE_RAW_CH),
        ADDR_W'(TRIG_LIVE_CH),
        ADDR_W'(TRIG_RAW_CH)
    };

    logic [NUM_SRC-1:0] src_async;
    logic [NUM_SRC-1:0] src_level;
    logic [NUM_SRC-1:0] src_rise;
    logic               busy_s;
    tick_t              trig_tick;
    tick_t              pulse_tick;
    logic [NUM_CH-1:0]  inc_vec;

    logic [NUM_CH-1:0][CNT_W-1:0] cnt_q;

    assign src_async = {pulse_in, trig_in};

    // Per-source synchronizer followed by a rising-edge detector.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        dtscal_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (src_async[s]),
            .dout (src_level[s])
        );
        dtscal_edge u_edge (
            .clk   (clk),
            .rst   (rst),
            .level (src_level[s]),
            .rise  (src_rise[s])
        );
    end

    // Busy takes the same synchronizer depth so it lines up with the edges.
    dtscal_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (busy_in),
        .dout (busy_s)
    );

    assign trig_tick  = gate_by_busy(src_rise[0], busy_s);
    assign pulse_tick = gate_by_busy(src_rise[1], busy_s);
    assign inc_vec    = pack_ticks(trig_tick, pulse_tick);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cnt
        dtscal_counter #(.W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .clr (clr_in),
            .inc (inc_vec[c]),
            .q   (cnt_q[c])
        );
    end

    dtscal_readmux #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .CH_MAP (CH_MAP)
    ) u_rdmux (
        .addr (rd_addr),
        .cnt  (cnt_q),
        .data (rd_data)
    );
endmodule

// File: rtl/dtscal_bank_chk.sv
module dtscal_bank_chk #(
    parameter int                             NUM_CH = 4,
    parameter int                             CNT_W  = 32,
    parameter int                             ADDR_W = 5,
    parameter logic [NUM_CH*ADDR_W-1:0]       CH_MAP = '0
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              clr,
    input logic [ADDR_W-1:0]                 rd_addr,
    input logic [CNT_W-1:0]                  rd_data,
    input logic [NUM_CH-1:0][CNT_W-1:0]      cnt
);
    logic addr_hit;

    always_comb begin
        addr_hit = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_addr == CH_MAP[i*ADDR_W +: ADDR_W]) addr_hit = 1'b1;
        end
    end

    // R6
    live_le_raw_trig_chk: assert property (@(posedge clk) disable iff (rst)
        cnt[1] <= cnt[0]);

    // R6
    live_le_raw_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cnt[3] <= cnt[2]);

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !addr_hit |-> rd_data == '0);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R7
        clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
            clr |=> cnt[c] == '0);

        // R8
        saturate_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (cnt[c] == {CNT_W{1'b1}} && !clr) |=> cnt[c] == {CNT_W{1'b1}});

        // R5
        single_step_chk: assert property (@(posedge clk) disable iff (rst)
            !clr |=> (cnt[c] == $past(cnt[c]) || cnt[c] == $past(cnt[c]) + 1'b1));
    end
endmodule

bind dtscal_bank dtscal_bank_chk #(
    .NUM_CH (dtscal_pkg::NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .CH_MAP (CH_MAP)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr_in),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .cnt     (cnt_q)
);

// File: tb/dtscal_bank_test.sv
`timescale 1ns/1ps
module dtscal_bank_test;
    localparam int W      = 4;
    localparam int AW     = 5;
    localparam int TOPV   = (1 << W) - 1;
    localparam int A_TR   = 9;
    localparam int A_TL   = 10;
    localparam int A_PR   = 11;
    localparam int A_PL   = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr_in = 1'b0;
    logic          trig_in = 1'b0;
    logic          pulse_in = 1'b0;
    logic          busy_in = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [W-1:0]  rd_data;

    int checks = 0;
    int errors = 0;
    int exp_tr = 0, exp_tl = 0, exp_pr = 0, exp_pl = 0;
    bit busy_m = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dtscal_bank #(.CNT_W(W), .ADDR_W(AW)) uut (
        .clk      (clk),
        .rst      (rst),
        .clr_in   (clr_in),
        .trig_in  (trig_in),
        .pulse_in (pulse_in),
        .busy_in  (busy_in),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    function automatic int sat_inc(input int v);
        return (v >= TOPV) ? TOPV : v + 1;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic read_ch(input int a, output int v);
        @(negedge clk);
        rd_addr = AW'(a);
        #1;
        v = int'(rd_data);
    endtask

    // Full sweep of the address space against the bench model.
    task automatic sweep(input string phase);
        int v;
        int e;
        string req;
        for (int a = 0; a < (1 << AW); a++) begin
            read_ch(a, v);
            case (a)
                A_TR:    begin e = exp_tr; req = "R1"; end
                A_TL:    begin e = exp_tl; req = "R2"; end
                A_PR:    begin e = exp_pr; req = "R3"; end
                A_PL:    begin e = exp_pl; req = "R4"; end
                default: begin e = 0;      req = "R9"; end
            endcase
            check(req, $sformatf("%s addr %0d", phase, a), v, e);
        end
    endtask

    task automatic set_busy(input bit b);
        @(negedge clk);
        busy_in = b;
        busy_m  = b;
        repeat (4) @(negedge clk);
    endtask

    // which: 0 = trigger, 1 = pulser, 2 = both together
    task automatic fire(input int which, input int len);
        @(negedge clk);
        if (which != 1) trig_in = 1'b1;
        if (which != 0) pulse_in = 1'b1;
        repeat (len) @(negedge clk);
        trig_in  = 1'b0;
        pulse_in = 1'b0;
        repeat (4) @(negedge clk);
        if (which != 1) begin
            exp_tr = sat_inc(exp_tr);
            if (!busy_m) exp_tl = sat_inc(exp_tl);
        end
        if (which != 0) begin
            exp_pr = sat_inc(exp_pr);
            if (!busy_m) exp_pl = sat_inc(exp_pl);
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr_in = 1'b1;
        @(negedge clk);
        clr_in = 1'b0;
        exp_tr = 0; exp_tl = 0; exp_pr = 0; exp_pl = 0;
    endtask

    initial begin
        int v, vr;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R10: reset state, every address zero
        sweep("R10 after reset");

        // Short pulses, not busy
        for (int i = 0; i < 3; i++) fire(0, 1);
        for (int i = 0; i < 2; i++) fire(1, 1);
        sweep("idle short");

        // R5: long pulses while busy; live counts must not move
        set_busy(1'b1);
        for (int i = 0; i < 2; i++) fire(0, 6);
        for (int i = 0; i < 4; i++) fire(1, 5);
        sweep("R5 busy long");
        read_ch(A_TL, v);
        check("R2", "live trigger frozen while busy", v, 3);
        read_ch(A_PL, v);
        check("R4", "vetoed pulser frozen while busy", v, 2);
        read_ch(A_PR, v);
        check("R5", "long pulses counted once", v, 6);

        // Both inputs together, busy alternating
        for (int i = 0; i < 6; i++) begin
            set_busy(i[0]);
            fire(2, 1 + (i % 3));
        end
        sweep("mixed");

        // R7: clear empties all
        do_clear();
        read_ch(A_TR, v);
        check("R7", "raw trigger after clear", v, 0);
        sweep("R7 after clear");

        // R8: drive past saturation, then more while busy
        set_busy(1'b0);
        for (int i = 0; i < TOPV + 4; i++) fire(2, 1);
        read_ch(A_TR, v);
        check("R8", "raw trigger saturated", v, TOPV);
        set_busy(1'b1);
        for (int i = 0; i < 3; i++) fire(2, 2);
        sweep("R8 saturated");
        read_ch(A_PL, v);
        read_ch(A_PR, vr);
        check("R6", "vetoed pulser not above free", (v <= vr) ? 1 : 0, 1);

        // R11: address change shows new data without a clock
        do_clear();
        set_busy(1'b0);
        fire(0, 1);
        @(negedge clk);
        rd_addr = AW'(A_TR);
        #1;
        v = int'(rd_data);
        rd_addr = AW'(A_PR);
        #1;
        check("R11", "same-cycle read trig", v, 1);
        check("R11", "same-cycle read pulser", int'(rd_data), 0);
        read_ch(A_TL, v);
        check("R6", "live trigger equals raw when idle", v, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule